// File: doc/BRIEF.md
# Universal Shift Register with Shared Parallel Bus

An 8-bit storage register that does one of four things on each rising clock edge: it keeps its contents, moves them one place towards the most significant bit, moves them one place towards the least significant bit, or takes a new word from a parallel bus. A two-bit mode input selects the operation. An active-low asynchronous reset clears the register at any time.

The parallel port is one bidirectional bus. It carries the load word into the register and shows the register contents when the register drives it. The pad-level tri-state driver is not part of the block. The block instead provides three signals: a sampled input word, a drive-data word and a drive-enable. The drive-enable is low whenever either of two active-low enables is high. It is also low whenever load mode is selected, so that an external source can drive the bus without contention.

The least and most significant bits also have their own outputs, which are driven at all times. Each shift direction has its own serial input. Wiring the top bit of one instance to the right-shift serial input of the next, and the bottom bit of the next back to the left-shift serial input of the first, gives a wider register that shifts in both directions.

Top module: `univ_shift_reg`

## Requirements
- R1: While rst_ni is low, the register is 0 at once, without waiting for a clock edge. Clock edges and mode_i have no effect until rst_ni returns high.
- R2: With mode_i = 2'b11 (load), a rising edge copies bus_i into the register.
- R3: With mode_i = 2'b01 (shift right), a rising edge moves each bit n to bit n+1, and ser_r_i enters bit 0.
- R4: With mode_i = 2'b10 (shift left), a rising edge moves each bit n to bit n-1, and ser_l_i enters the top bit.
- R5: With mode_i = 2'b00 (hold), a rising edge leaves the register unchanged.
- R6: bus_oe_o is high exactly when oe_a_ni and oe_b_ni are both low and mode_i is not 2'b11. This holds during reset as well. bus_o always equals the register contents.
- R7: With the drive-enable low, shift, hold, load and reset behave exactly as they do with the bus driven.
- R8: q_lsb_o and q_msb_o always equal register bits 0 and WIDTH-1, whatever the enables are.
- R9: Two instances wired as a cascade (top bit to the next ser_r_i, bottom bit back to the previous ser_l_i) act as a single register of twice the width in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; state changes on the rising edge |
| rst_ni | input | 1 | Asynchronous clear, active low |
| mode_i | input | 2 | 00 hold, 01 shift right, 10 shift left, 11 load |
| ser_r_i | input | 1 | Serial input entering bit 0 on a right shift |
| ser_l_i | input | 1 | Serial input entering the top bit on a left shift |
| oe_a_ni | input | 1 | Bus drive enable A, active low |
| oe_b_ni | input | 1 | Bus drive enable B, active low |
| bus_i | input | WIDTH | Word sampled from the shared bus on load |
| bus_o | output | WIDTH | Word driven onto the shared bus (register contents) |
| bus_oe_o | output | 1 | High when the bus should be driven |
| q_lsb_o | output | 1 | Register bit 0, always driven |
| q_msb_o | output | 1 | Register bit WIDTH-1, always driven |

## Verification
A wrong bit in the register shows on bus_o in the cycle it occurs, because bus_o has no gating. Under right or left shifts it also reaches q_msb_o or q_lsb_o within at most WIDTH edges, and from there it reaches the next cascaded stage. A bad mode decode shows after a single edge as a word that is moved the wrong way or not moved at all. A bad drive-enable shows in the same cycle, with no clock needed, including while reset is held.

// File: rtl/usr_pkg.sv
package usr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_SHR  = 2'b01,
    MODE_SHL  = 2'b10,
    MODE_LOAD = 2'b11
  } mode_e;

  typedef struct packed {
    logic load;
    logic shr;
    logic shl;
    logic hold;
  } op_t;
endpackage

// File: rtl/usr_mode_dec.sv
module usr_mode_dec
  import usr_pkg::*;
(
  input  logic [1:0] mode_i,
  output op_t        op_o
);
  mode_e mode;

  always_comb begin
    mode = mode_e'(mode_i);
    op_o = '0;
    unique case (mode)
      MODE_LOAD: op_o.load = 1'b1;
      MODE_SHR:  op_o.shr  = 1'b1;
      MODE_SHL:  op_o.shl  = 1'b1;
      default:   op_o.hold = 1'b1;
    endcase
  end
endmodule

// File: rtl/usr_core.sv
module usr_core
  import usr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  op_t              op_i,
  input  logic             ser_r_i,
  input  logic             ser_l_i,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q_d;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic from_lo, from_hi;
    if (i == 0) begin : g_lo_end
      assign from_lo = ser_r_i;
    end else begin : g_lo_mid
      assign from_lo = q_o[i-1];
    end
    if (i == WIDTH-1) begin : g_hi_end
      assign from_hi = ser_l_i;
    end else begin : g_hi_mid
      assign from_hi = q_o[i+1];
    end

    always_comb begin
      if (op_i.load)     q_d[i] = din_i[i];
      else if (op_i.shr) q_d[i] = from_lo;
      else if (op_i.shl) q_d[i] = from_hi;
      else               q_d[i] = q_o[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= q_d;
  end

  a_r1_reset_clear: assert property (@(posedge clk_i) !rst_ni |-> q_o == '0);
  a_r2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i.load |=> q_o == $past(din_i));
  a_r3_shift_right: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i.shr |=> q_o == {$past(q_o[WIDTH-2:0]), $past(ser_r_i)});
  a_r4_shift_left: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i.shl |=> q_o == {$past(ser_l_i), $past(q_o[WIDTH-1:1])});
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i.hold |=> $stable(q_o));
endmodule

// File: rtl/usr_bus_ctl.sv
module usr_bus_ctl #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             load_i,
  input  logic             oe_a_ni,
  input  logic             oe_b_ni,
  input  logic [WIDTH-1:0] q_i,
  output logic [WIDTH-1:0] bus_o,
  output logic             bus_oe_o,
  output logic             q_lsb_o,
  output logic             q_msb_o
);
  // load mode releases the bus so an external source can drive it
  assign bus_oe_o = ~(oe_a_ni | oe_b_ni | load_i);
  assign bus_o    = q_i;
  assign q_lsb_o  = q_i[0];
  assign q_msb_o  = q_i[WIDTH-1];
endmodule

// File: rtl/univ_shift_reg.sv
module univ_shift_reg
  import usr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             ser_r_i,
  input  logic             ser_l_i,
  input  logic             oe_a_ni,
  input  logic             oe_b_ni,
  input  logic [WIDTH-1:0] bus_i,
  output logic [WIDTH-1:0] bus_o,
  output logic             bus_oe_o,
  output logic             q_lsb_o,
  output logic             q_msb_o
);
  op_t              op;
  logic [WIDTH-1:0] q;

  usr_mode_dec i_dec (
    .mode_i (mode_i),
    .op_o   (op)
  );

  usr_core #(.WIDTH(WIDTH)) i_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (op),
    .ser_r_i (ser_r_i),
    .ser_l_i (ser_l_i),
    .din_i   (bus_i),
    .q_o     (q)
  );

  usr_bus_ctl #(.WIDTH(WIDTH)) i_bus (
    .load_i   (op.load),
    .oe_a_ni  (oe_a_ni),
    .oe_b_ni  (oe_b_ni),
    .q_i      (q),
    .bus_o    (bus_o),
    .bus_oe_o (bus_oe_o),
    .q_lsb_o  (q_lsb_o),
    .q_msb_o  (q_msb_o)
  );

  // R6 also holds during reset, hence no disable
  a_r6_no_drive: assert property (@(posedge clk_i)
    (mode_i == 2'b11 || oe_a_ni || oe_b_ni) |-> !bus_oe_o);
  a_r6_drive_on: assert property (@(posedge clk_i)
    (mode_i != 2'b11 && !oe_a_ni && !oe_b_ni) |-> bus_oe_o);
  a_r5_op_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(op) == 1);
  a_r8_end_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_lsb_o == bus_o[0] && q_msb_o == bus_o[WIDTH-1]);
endmodule

// File: tb/test_univ_shift_reg.sv
module test_univ_shift_reg;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic [1:0] mode = 2'b00;
  logic sr = 1'b0, sl = 1'b0, oea = 1'b1, oeb = 1'b1;
  logic [2*W-1:0] din = '0;

  logic [W-1:0] bo_lo, bo_hi;
  logic oe_lo, oe_hi, lsb_lo, msb_lo, lsb_hi, msb_hi;

  logic [2*W-1:0] model = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  univ_shift_reg #(.WIDTH(W)) i_univ_shift_reg (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .ser_r_i(sr), .ser_l_i(lsb_hi),
    .oe_a_ni(oea), .oe_b_ni(oeb), .bus_i(din[W-1:0]), .bus_o(bo_lo),
    .bus_oe_o(oe_lo), .q_lsb_o(lsb_lo), .q_msb_o(msb_lo));

  univ_shift_reg #(.WIDTH(W)) i_univ_shift_reg_hi (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .ser_r_i(msb_lo), .ser_l_i(sl),
    .oe_a_ni(oea), .oe_b_ni(oeb), .bus_i(din[2*W-1:W]), .bus_o(bo_hi),
    .bus_oe_o(oe_hi), .q_lsb_o(lsb_hi), .q_msb_o(msb_hi));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string mode_tag(logic [1:0] m);
    case (m)
      2'b11:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic compare_all(logic [1:0] m);
    logic exp_oe;
    exp_oe = (m != 2'b11) && !oea && !oeb;
    check(((oea | oeb) ? "R7" : mode_tag(m)), {24'h0, bo_lo}, {24'h0, model[W-1:0]});
    check("R9", {24'h0, bo_hi}, {24'h0, model[2*W-1:W]});
    check("R8", {28'h0, msb_hi, lsb_hi, msb_lo, lsb_lo},
          {28'h0, model[2*W-1], model[W], model[W-1], model[0]});
    check("R6", {30'h0, oe_hi, oe_lo}, {30'h0, exp_oe, exp_oe});
  endtask

  // drive at negedge, model updates on the edge, compare on the next negedge
  task automatic step(logic [1:0] m, logic s_r, logic s_l, logic [2*W-1:0] d,
                      logic a, logic b);
    mode = m; sr = s_r; sl = s_l; din = d; oea = a; oeb = b;
    @(posedge clk);
    case (m)
      2'b11: model = d;
      2'b01: model = {model[2*W-2:0], s_r};
      2'b10: model = {s_l, model[2*W-1:1]};
      default: ;
    endcase
    @(negedge clk);
    compare_all(m);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #2 rst_n = 1'b0;
    #1;
    check("R1", {16'h0, bo_hi, bo_lo}, 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model = '0;
    compare_all(2'b00);

    // load with enables low: bus released (R6), word captured (R2)
    step(2'b11, 0, 0, 16'hA5C3, 0, 0);
    repeat (3) step(2'b00, 1, 1, 16'hFFFF, 0, 0);
    // right shifts crossing the cascade boundary (R3, R9)
    for (int i = 0; i < 20; i++) step(2'b01, 1'(i % 3 == 0), 0, '0, 0, 0);
    // left shifts (R4, R9)
    for (int i = 0; i < 20; i++) step(2'b10, 0, 1'(i % 2), '0, 0, 0);
    // bus disabled by either enable: register keeps working (R7)
    step(2'b11, 0, 0, 16'h3C81, 1, 0);
    for (int i = 0; i < 6; i++) step(2'b01, 1, 0, '0, 0, 1);
    for (int i = 0; i < 6; i++) step(2'b10, 0, 1, '0, 1, 1);
    step(2'b00, 0, 0, '0, 1, 0);
    // mixed patterns
    for (int i = 0; i < 300; i++)
      step(2'($urandom), 1'($urandom), 1'($urandom), 16'($urandom),
           1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) == 0));

    // asynchronous reset mid-cycle while shifting (R1), enables low (R6)
    step(2'b11, 0, 0, 16'hFFFF, 0, 0);
    mode = 2'b01; oea = 0; oeb = 0;
    #2 rst_n = 1'b0;
    #1;
    check("R1", {16'h0, bo_hi, bo_lo}, 32'h0);
    check("R6", {31'h0, oe_lo}, 32'h1);
    mode = 2'b11; din = 16'hBEEF;
    #1;
    check("R6", {30'h0, oe_hi, oe_lo}, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R1", {16'h0, bo_hi, bo_lo}, 32'h0);
    rst_n = 1'b1;
    model = '0;
    step(2'b01, 1, 0, '0, 1, 1);
    step(2'b11, 0, 0, 16'h8001, 0, 0);
    step(2'b10, 0, 0, '0, 0, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule